// File: doc/BRIEF.md
# Framed Serial Transmitter with Programmable Parity and Line Levels

This block turns a parallel data word into an asynchronous serial frame on one output line. A frame has a start bit, the data bits sent least significant bit first, an optional parity bit and one stop bit. Bit timing comes from an external strobe, `bit_tick_i`. Each bit stays on the line for exactly one strobe interval. The strobe is typically high for one clock out of every sixteen.

The line levels for the start bit and for the stop/idle condition are live inputs. Driving the stop level to 0 holds a break on the line. A stick control replaces the computed parity with a fixed bit.

A one-cycle `send_i` pulse starts a frame. The pulse is only accepted when the block is idle. It captures the data word and the three parity controls. The frame then begins at the next strobe. `busy_o` tells the producer when it may send again.

Top module: `serial_tx_frame`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o` is 0 and `line_o` equals `stop_lvl_i`.
- R2: A `send_i` pulse while idle captures `data_i`, `par_en_i`, `par_even_i` and `par_stick_i`. `busy_o` goes high on the next cycle and stays high until the strobe that ends the stop bit.
- R3: The start bit begins at the first `bit_tick_i` after the accepted pulse. It drives `start_lvl_i` for one strobe interval.
- R4: The data bits follow the start bit, least significant first. Each bit lasts one strobe interval.
- R5: With `par_en_i`=1 and `par_stick_i`=0, a parity bit follows the data bits. With `par_even_i`=1 the parity bit is the XOR of the data bits. With `par_even_i`=0 it is the inverse of that XOR.
- R6: With `par_en_i`=0, the stop bit directly follows the last data bit.
- R7: With `par_en_i`=1 and `par_stick_i`=1, the parity bit equals the inverse of `par_even_i`, whatever the data.
- R8: The stop bit drives `stop_lvl_i` for one strobe interval. While idle, `line_o` follows `stop_lvl_i`, so a value of 0 holds a break. `busy_o` only falls on a strobe.
- R9: A `send_i` pulse while `busy_o` is high is ignored. The frame in progress and its data are unchanged.
- R10: On a cycle where `bit_tick_i` is low, the frame does not advance. `busy_o` and `line_o` keep their values, unless a level input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | DATA_W | Word to transmit, captured on an accepted pulse |
| send_i | input | 1 | One-cycle start request |
| bit_tick_i | input | 1 | Bit-rate strobe |
| par_en_i | input | 1 | 1 inserts a parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| par_stick_i | input | 1 | 1 makes the parity bit the inverse of `par_even_i` |
| start_lvl_i | input | 1 | Line level during the start bit |
| stop_lvl_i | input | 1 | Line level during the stop bit and idle |
| line_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
The assertions check these properties on every cycle:
- The line follows the stop level while idle.
- An accepted pulse raises busy.
- Nothing moves between strobes.
- Busy only falls on a strobe.

Only the bench scenarios can show frame content. The bench samples each bit in the middle of its interval to check:
- The bit order and the parity value for both parity senses.
- The stick value and the no-parity layout.
- A non-default start level and a held break.
- That a second request during a frame leaves the data unchanged.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_PAR   = 3'd4,
        ST_STOP  = 3'd5
    } tx_state_e;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              even_i,
    input  logic              stick_i,
    output logic              bit_o
);
    logic xor_all;

    always_comb begin
        xor_all = ^word_i;
        if (stick_i)
            bit_o = ~even_i;
        else if (even_i)
            bit_o = xor_all;
        else
            bit_o = ~xor_all;
    end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      send_i,
    input  logic      tick_i,
    input  logic      par_en_i,
    output tx_state_e state_o,
    output logic      accept_o,
    output logic      shift_o
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic          par_en;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        accept_o = 1'b0;
        shift_o  = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (send_i) begin
                    accept_o     = 1'b1;
                    fsm_d.st     = ST_ARM;
                    fsm_d.par_en = par_en_i;
                end
            end
            ST_ARM:   if (tick_i) fsm_d.st = ST_START;
            ST_START: begin
                if (tick_i) begin
                    fsm_d.st  = ST_DATA;
                    fsm_d.cnt = '0;
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    shift_o = 1'b1;
                    if (fsm_q.cnt == LAST)
                        fsm_d.st = fsm_q.par_en ? ST_PAR : ST_STOP;
                    else
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_PAR:   if (tick_i) fsm_d.st = ST_STOP;
            ST_STOP:  if (tick_i) fsm_d.st = ST_IDLE;
            default:  fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fsm_q.st     <= ST_IDLE;
            fsm_q.cnt    <= '0;
            fsm_q.par_en <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;
endmodule

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              par_i,
    output logic              lsb_o,
    output logic              par_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              par;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d.sh  = word_i;
            sr_d.par = par_i;
        end else if (shift_i) begin
            sr_d.sh = {1'b0, sr_q.sh[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q.sh  <= '0;
            sr_q.par <= 1'b0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign lsb_o = sr_q.sh[0];
    assign par_o = sr_q.par;
endmodule

// File: rtl/serial_tx_frame.sv
module serial_tx_frame
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              send_i,
    input  logic              bit_tick_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_stick_i,
    input  logic              start_lvl_i,
    input  logic              stop_lvl_i,
    output logic              line_o,
    output logic              busy_o
);
    tx_state_e state;
    logic      accept, shift, par_bit, lsb, par_q;

    sertx_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .send_i   (send_i),
        .tick_i   (bit_tick_i),
        .par_en_i (par_en_i),
        .state_o  (state),
        .accept_o (accept),
        .shift_o  (shift)
    );

    sertx_parity #(.DATA_W(DATA_W)) i_par (
        .word_i  (data_i),
        .even_i  (par_even_i),
        .stick_i (par_stick_i),
        .bit_o   (par_bit)
    );

    sertx_shreg #(.DATA_W(DATA_W)) i_sr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (accept),
        .shift_i (shift),
        .word_i  (data_i),
        .par_i   (par_bit),
        .lsb_o   (lsb),
        .par_o   (par_q)
    );

    always_comb begin
        unique case (state)
            ST_START: line_o = start_lvl_i;
            ST_DATA:  line_o = lsb;
            ST_PAR:   line_o = par_q;
            default:  line_o = stop_lvl_i;
        endcase
    end

    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/sertx_sva.sv
module sertx_sva (
    input logic clk_i,
    input logic rst_i,
    input logic send_i,
    input logic bit_tick_i,
    input logic start_lvl_i,
    input logic stop_lvl_i,
    input logic line_o,
    input logic busy_o
);
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (line_o == stop_lvl_i)); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (send_i && !busy_o) |=> busy_o); // R2

    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !bit_tick_i) |=> busy_o); // R10

    AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !bit_tick_i) |=>
            ($stable(line_o) || !$stable(start_lvl_i) || !$stable(stop_lvl_i))); // R10

    AST_BUSY_FALL_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> $past(bit_tick_i)); // R8

    AST_BUSY_SEND_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && send_i && !bit_tick_i) |=> busy_o); // R9
endmodule

bind serial_tx_frame sertx_sva i_sva (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .send_i      (send_i),
    .bit_tick_i  (bit_tick_i),
    .start_lvl_i (start_lvl_i),
    .stop_lvl_i  (stop_lvl_i),
    .line_o      (line_o),
    .busy_o      (busy_o)
);

// File: tb/test_serial_tx_frame.sv
module test_serial_tx_frame;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int TICK_DIV = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] data = '0;
    logic          send = 1'b0;
    logic          tick = 1'b0;
    logic          par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic          start_lvl = 1'b0, stop_lvl = 1'b1;
    logic          line, busy;

    int total = 0;
    int bad = 0;

    serial_tx_frame #(.DATA_W(DW)) i_serial_tx_frame (
        .clk_i       (clk),
        .rst_i       (rst),
        .data_i      (data),
        .send_i      (send),
        .bit_tick_i  (tick),
        .par_en_i    (par_en),
        .par_even_i  (par_even),
        .par_stick_i (par_stick),
        .start_lvl_i (start_lvl),
        .stop_lvl_i  (stop_lvl),
        .line_o      (line),
        .busy_o      (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            tick = (c == TICK_DIV - 1);
            c = (c + 1) % TICK_DIV;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 line in reset", line, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 line after reset", line, stop_lvl);
    endtask

    task automatic run_frame(input logic [DW-1:0] d, input logic en, input logic ev,
                             input logic st, input logic s_lvl, input logic inject);
        logic p;
        p = st ? ~ev : (ev ? ^d : ~^d);
        @(negedge clk);
        data = d; par_en = en; par_even = ev; par_stick = st; start_lvl = s_lvl;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        par_en = ~en; par_even = ~ev; par_stick = ~st;
        chk("R2 busy after send", busy, 1'b1);
        do @(posedge clk); while (!tick);
        repeat (TICK_DIV/2) @(negedge clk);
        chk("R3 start level", line, s_lvl);
        chk("R2 busy in frame", busy, 1'b1);
        for (int i = 0; i < DW; i++) begin
            repeat (TICK_DIV) @(negedge clk);
            chk(inject ? "R9 data bit" : "R4 data bit", line, d[i]);
            if (inject && i == 2) begin
                data = ~d; send = 1'b1;
            end else begin
                send = 1'b0;
            end
        end
        send = 1'b0;
        if (en) begin
            repeat (TICK_DIV) @(negedge clk);
            chk(st ? "R7 stick parity" : "R5 parity bit", line, p);
        end
        repeat (TICK_DIV) @(negedge clk);
        chk(en ? "R8 stop bit" : "R6 stop after data", line, stop_lvl);
        chk("R2 busy in stop", busy, 1'b1);
        repeat (TICK_DIV) @(negedge clk);
        chk("R8 idle after stop", busy, 1'b0);
        chk("R8 idle line", line, stop_lvl);
        start_lvl = 1'b0;
    endtask

    task automatic t_even();   run_frame(8'h34, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_odd();    run_frame(8'hF1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_odd2();   run_frame(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_stick1(); run_frame(8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); endtask
    task automatic t_stick0(); run_frame(8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); endtask
    task automatic t_nopar();  run_frame(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_startlv(); run_frame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); endtask
    task automatic t_ignore(); run_frame(8'h96, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); endtask

    task automatic t_break();
        @(negedge clk);
        stop_lvl = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 break line", line, 1'b0);
        chk("R8 break busy", busy, 1'b0);
        stop_lvl = 1'b1;
        @(negedge clk);
        chk("R8 break release", line, 1'b1);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_even();
        t_odd();
        t_odd2();
        t_stick1();
        t_stick0();
        t_nopar();
        t_startlv();
        t_ignore();
        t_break();
        finish_up();
    end
endmodule